// File: doc/BRIEF.md
# Piecewise-Linear Activation Unit

This block applies a run-time programmable activation function to a stream of signed fixed-point words. Each word has 8 integer bits and 8 fractional bits. The function is split into `NSEG` straight-line pieces. Each piece has a starting threshold, a gradient and an offset, and all three sit in a small register table. An incoming word is placed in the piece whose range holds it. The result is the word times that piece's gradient, scaled back to the same number format, plus the piece's offset. With suitable pieces the unit can approximate a sigmoid, a hyperbolic tangent or a plain rectifier.

Words arrive with a valid flag and may come on every clock. Each result leaves with its own valid flag a fixed two cycles later, and results stay in input order. The table is loaded through a word-wide write port, one field of one piece per write. Loading is meant to happen between planes of data. A write made while words are still in flight is not defined.

Top module: `pwl_act`

## Requirements
- R1: After reset `out_valid` is 0 and `out_data` is 0. Every table field is zero, so each word streamed before any table write gives a result of 0.
- R2: A word x uses the highest piece m (1 ≤ m < NSEG) whose threshold satisfies x ≥ threshold, compared as signed values. A word equal to a threshold uses that threshold's piece. Words below the threshold of piece 1 use piece 0. Piece 0 stores no threshold, so a threshold write to index 0 has no effect.
- R3: A word at or above the threshold of the last piece (index NSEG-1) uses the last piece, up to the largest positive input.
- R4: The result is floor(g·x / 256) + c. Here g is the gradient and c the offset of the chosen piece. The product is shifted right arithmetically by 8, so it rounds toward minus infinity.
- R5: A word accepted at a clock edge with `in_valid` = 1 appears on `out_data` with `out_valid` = 1 two edges later. `out_valid` is 0 two edges after any edge at which `in_valid` was 0. Back-to-back words give back-to-back results.
- R6: A result above 32767 is output as 32767 (0x7FFF). A result below -32768 is output as -32768 (0x8000).
- R7: While `out_valid` is 0, `out_data` keeps the last result that was output.
- R8: A write with `tbl_we` = 1 stores `tbl_wdata` into piece `tbl_idx`. `tbl_field` picks the field: 0 threshold, 1 gradient, 2 offset. Code 3 changes nothing. The new value applies to words accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | DATA_W | Signed fixed-point input word |
| tbl_we | input | 1 | Table write strobe |
| tbl_field | input | 2 | Field select: 0 threshold, 1 gradient, 2 offset, 3 none |
| tbl_idx | input | SEG_IDX_W | Piece index for the write |
| tbl_wdata | input | DATA_W | Value written into the table |
| out_valid | output | 1 | Result qualifier |
| out_data | output | DATA_W | Signed fixed-point result |

## Verification
Two things can happen in the same clock. A new word can be placed in its piece while the word before it is still in the multiply-add stage, possibly in a different piece, with a different gradient, or clamping. The bench drives long gap-free runs of words that sit just below, on and just above each threshold, and mixes in words that clamp at both ends. A behavioural model in the bench predicts the valid flag and the data on every clock. A result that borrows its neighbour's piece or coefficients therefore shows up as a mismatch in that exact cycle.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
   typedef enum logic [1:0] {
      FLD_BOUND = 2'd0,
      FLD_SLOPE = 2'd1,
      FLD_ICPT  = 2'd2,
      FLD_NONE  = 2'd3
   } tbl_field_e;
endpackage

// File: rtl/pwl_table.sv
module pwl_table #(
   parameter int NSEG  = 8,
   parameter int DW    = 16,
   parameter int IW    = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [1:0]                    field_i,
   input  logic [IW-1:0]                 idx_i,
   input  logic [DW-1:0]                 wdata_i,
   output logic [NSEG-1:1][DW-1:0]       bound_o,
   output logic [NSEG-1:0][DW-1:0]       slope_o,
   output logic [NSEG-1:0][DW-1:0]       icpt_o
);
   import pwl_pkg::*;

   tbl_field_e fld;
   assign fld = tbl_field_e'(field_i);

   for (genvar m = 0; m < NSEG; m++) begin : g_seg
      logic hit;
      assign hit = we_i && (idx_i == IW'(m));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slope_o[m] <= '0;
            icpt_o[m]  <= '0;
         end else if (hit) begin
            if (fld == FLD_SLOPE) slope_o[m] <= wdata_i;
            if (fld == FLD_ICPT)  icpt_o[m]  <= wdata_i;
         end
      end

      if (m > 0) begin : g_bound
         always_ff @(posedge clk) begin
            if (!rst_n)                          bound_o[m] <= '0;
            else if (hit && fld == FLD_BOUND)    bound_o[m] <= wdata_i;
         end
      end
   end

   AST_TBL_SLOPE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && field_i == 2'd1) |=> slope_o[$past(idx_i)] == $past(wdata_i)); // R8
   AST_TBL_ICPT_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && field_i == 2'd2) |=> icpt_o[$past(idx_i)] == $past(wdata_i)); // R8
endmodule

// File: rtl/pwl_select.sv
module pwl_select #(
   parameter int NSEG = 8,
   parameter int DW   = 16,
   parameter int IW   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     v_i,
   input  logic [DW-1:0]            x_i,
   input  logic [NSEG-1:1][DW-1:0]  bound_i,
   output logic                     v_o,
   output logic [DW-1:0]            x_o,
   output logic [IW-1:0]            seg_o
);
   logic [NSEG-1:1] ge;
   logic [IW-1:0]   seg_d;

   for (genvar m = 1; m < NSEG; m++) begin : g_cmp
      assign ge[m] = $signed(x_i) >= $signed(bound_i[m]);
   end

   always_comb begin
      seg_d = '0;
      for (int m = 1; m < NSEG; m++) begin
         if (ge[m]) seg_d = IW'(m);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         x_o   <= '0;
         seg_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            x_o   <= x_i;
            seg_o <= seg_d;
         end
      end
   end

   AST_SEG_ABOVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (v_o && seg_o != '0) |-> $signed(x_o) >= $signed(bound_i[seg_o])); // R2
   AST_SEG_BELOW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (v_o && seg_o != IW'(NSEG-1)) |-> $signed(x_o) < $signed(bound_i[seg_o + 1'b1])); // R3
endmodule

// File: rtl/pwl_mac.sv
module pwl_mac #(
   parameter int DW = 16,
   parameter int FW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] slope_i,
   input  logic [DW-1:0] icpt_i,
   output logic          v_o,
   output logic [DW-1:0] y_o
);
   localparam int PW = 2 * DW;
   localparam int SW = PW + 1;
   localparam logic signed [SW-1:0] SAT_HI = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;

   logic signed [PW-1:0] prod, prod_sh;
   logic signed [SW-1:0] sum_full;

   assign prod     = $signed(x_i) * $signed(slope_i);
   assign prod_sh  = prod >>> FW;
   assign sum_full = $signed({prod_sh[PW-1], prod_sh})
                   + $signed({{(SW-DW){icpt_i[DW-1]}}, icpt_i});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         y_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            if (sum_full > SAT_HI)      y_o <= SAT_HI[DW-1:0];
            else if (sum_full < SAT_LO) y_o <= SAT_LO[DW-1:0];
            else                        y_o <= sum_full[DW-1:0];
         end
      end
   end

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && sum_full > SAT_HI) |=> y_o == {1'b0, {(DW-1){1'b1}}}); // R6
   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && sum_full < SAT_LO) |=> y_o == {1'b1, {(DW-1){1'b0}}}); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> $stable(y_o)); // R7
endmodule

// File: rtl/pwl_act.sv
module pwl_act #(
   parameter int DATA_W    = 16,
   parameter int FRAC_W    = 8,
   parameter int NSEG      = 8,
   parameter int SEG_IDX_W = $clog2(NSEG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [DATA_W-1:0]    in_data,
   input  logic                 tbl_we,
   input  logic [1:0]           tbl_field,
   input  logic [SEG_IDX_W-1:0] tbl_idx,
   input  logic [DATA_W-1:0]    tbl_wdata,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    out_data
);
   if (NSEG < 2) begin : g_chk_nseg
      $error("pwl_act: NSEG must be at least 2");
   end
   if ((1 << SEG_IDX_W) < NSEG) begin : g_chk_idx
      $error("pwl_act: SEG_IDX_W too narrow for NSEG");
   end
   if (FRAC_W >= DATA_W || FRAC_W < 1) begin : g_chk_frac
      $error("pwl_act: FRAC_W must lie in 1..DATA_W-1");
   end

   logic [NSEG-1:1][DATA_W-1:0] bound_all;
   logic [NSEG-1:0][DATA_W-1:0] slope_all, icpt_all;
   logic                        s1_v;
   logic [DATA_W-1:0]           s1_x;
   logic [SEG_IDX_W-1:0]        s1_seg;

   pwl_table #(.NSEG(NSEG), .DW(DATA_W), .IW(SEG_IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .we_i(tbl_we), .field_i(tbl_field),
      .idx_i(tbl_idx), .wdata_i(tbl_wdata),
      .bound_o(bound_all), .slope_o(slope_all), .icpt_o(icpt_all));

   pwl_select #(.NSEG(NSEG), .DW(DATA_W), .IW(SEG_IDX_W)) u_select (
      .clk(clk), .rst_n(rst_n), .v_i(in_valid), .x_i(in_data),
      .bound_i(bound_all), .v_o(s1_v), .x_o(s1_x), .seg_o(s1_seg));

   pwl_mac #(.DW(DATA_W), .FW(FRAC_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .v_i(s1_v), .x_i(s1_x),
      .slope_i(slope_all[s1_seg]), .icpt_i(icpt_all[s1_seg]),
      .v_o(out_valid), .y_o(out_data));

   AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid); // R5
   AST_LAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid); // R5
endmodule

// File: tb/tb_pwl_act.sv
module tb_pwl_act;
   localparam int CLK_P = 10;
   localparam int NSEG  = 8;
   localparam int DW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          tbl_we = 1'b0;
   logic [1:0]    tbl_field = '0;
   logic [2:0]    tbl_idx = '0;
   logic [DW-1:0] tbl_wdata = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;

   int n_run = 0;
   int n_fail = 0;
   int cycles = 0;
   string cur_req = "R1";

   pwl_act #(.DATA_W(DW), .FRAC_W(8), .NSEG(NSEG)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .tbl_we(tbl_we), .tbl_field(tbl_field), .tbl_idx(tbl_idx),
      .tbl_wdata(tbl_wdata), .out_valid(out_valid), .out_data(out_data));

   always #(CLK_P/2) clk = ~clk;

   // behavioural reference model
   int m_bnd [NSEG];
   int m_slp [NSEG];
   int m_icp [NSEG];
   bit s1_v, e_v;
   int s1_d, e_d;

   function automatic int ref_calc(int x);
      int     seg = 0;
      longint r;
      for (int m = 1; m < NSEG; m++) if (x >= m_bnd[m]) seg = m;
      r = (longint'(m_slp[seg]) * longint'(x)) >>> 8;
      r = r + longint'(m_icp[seg]);
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return int'(r);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int m = 0; m < NSEG; m++) begin
            m_bnd[m] = 0; m_slp[m] = 0; m_icp[m] = 0;
         end
         s1_v = 0; s1_d = 0; e_v = 0; e_d = 0;
      end else begin
         e_v = s1_v;
         if (s1_v) e_d = s1_d;
         s1_v = in_valid;
         if (in_valid) s1_d = ref_calc(int'($signed(in_data)));
         if (tbl_we) begin
            case (tbl_field)
               2'd0: if (tbl_idx != 0) m_bnd[tbl_idx] = int'($signed(tbl_wdata));
               2'd1: m_slp[tbl_idx] = int'($signed(tbl_wdata));
               2'd2: m_icp[tbl_idx] = int'($signed(tbl_wdata));
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_run++;
         if (out_valid !== e_v) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", cur_req, out_valid, e_v);
         end
         n_run++;
         if (int'($signed(out_data)) !== e_d) begin
            n_fail++;
            $display("FAIL %s out_data actual=%0d expected=%0d", cur_req,
                     int'($signed(out_data)), e_d);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic send(input int x);
      in_valid = 1'b1;
      in_data  = DW'(x);
      tick();
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) tick();
   endtask

   task automatic wr(input int f, input int i, input int d);
      tbl_we    = 1'b1;
      tbl_field = 2'(f);
      tbl_idx   = 3'(i);
      tbl_wdata = DW'(d);
      tick();
      tbl_we = 1'b0;
   endtask

   initial begin
      int bnds [NSEG] = '{0, -768, -256, 0, 256, 512, 1024, 1536};
      int slps [NSEG] = '{16, 64, 256, 384, -128, 512, 0, 256};
      int icps [NSEG] = '{-256, 32, 0, 16, 768, -512, 1024, 80};
      void'($urandom(13));
      repeat (3) tick();
      // R1: reset state
      n_run++;
      if (out_valid !== 1'b0 || out_data !== '0) begin
         n_fail++;
         $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_valid, out_data);
      end
      rst_n = 1'b1;
      tick();
      cur_req = "R1";
      send(1000); send(-5000); send(32767); send(-32768);
      idle(3);

      // R8: program table, with a no-effect field code and a no-effect index-0 bound
      cur_req = "R8";
      for (int m = 0; m < NSEG; m++) begin
         wr(0, m, bnds[m]);
         wr(1, m, slps[m]);
         wr(2, m, icps[m]);
      end
      wr(3, 2, 12345);
      wr(3, 5, -999);
      wr(0, 0, 30000);
      idle(2);
      send(-300); send(100); send(700);
      idle(3);

      // R2: thresholds exactly, just below, just above, back to back
      cur_req = "R2";
      for (int m = 1; m < NSEG; m++) begin
         send(bnds[m] - 1); send(bnds[m]); send(bnds[m] + 1);
      end
      send(-32768); send(-800); send(-769);
      idle(3);

      // R3: at and above the last threshold
      cur_req = "R3";
      send(1536); send(2000); send(20000); send(32767);
      idle(3);

      // R4: arithmetic over random words, including odd products that round down
      cur_req = "R4";
      for (int k = 0; k < 60; k++) send(int'($signed(16'($urandom_range(0, 65535)))));
      send(-1); send(-3); send(3);
      idle(3);

      // R7: gaps between words, output holds
      cur_req = "R7";
      for (int k = 0; k < 12; k++) begin
         send(int'($signed(16'($urandom_range(0, 65535)))));
         idle(1 + (k % 3));
      end
      idle(2);

      // R6: saturation at both ends, mixed with in-range words
      cur_req = "R6";
      wr(1, 7, 32767);
      wr(1, 0, 32767);
      wr(2, 6, 32767);
      idle(2);
      send(32767); send(-32768); send(1200); send(2000); send(-20000); send(0);
      idle(3);

      // R5: long gap-free run across all pieces
      cur_req = "R5";
      for (int k = 0; k < 80; k++) begin
         if (k % 4 == 0) send(bnds[1 + (k / 4) % (NSEG - 1)]);
         else            send(int'($signed(16'($urandom_range(0, 65535)))));
      end
      idle(4);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule